// File: doc/BRIEF.md
# Vector Lane Swizzle and Broadcast Operand Stage

This block shapes one source operand before it reaches a vector ALU. The operand is a 512-bit vector of sixteen 32-bit elements, grouped as four 128-bit lanes of four elements each. Inside a lane the elements are called a (least significant) through d. Lane 0 occupies the low end of the vector, and element a of lane 0 sits in bits [31:0].

For each accepted request the stage can do one of four things:

- apply one of eight fixed in-lane permutations to a register operand;
- expand a memory read into a full vector by broadcast;
- shuffle the elements inside every lane under an 8-bit immediate;
- shuffle whole lanes under an 8-bit immediate.

Every operation is built from two permute layers. The first is an in-lane element crossbar. The second is a lane crossbar. Each layer is steered by an 8-bit select word. The result, a valid flag and an error flag are registered, so the result appears one clock after the request.

Top module: `vec_operand_shaper`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with no request yet taken, `res_valid`, `res_err` and `res_vec` are all zero.
- R2: `res_valid` equals the value `req_valid` had at the previous rising edge. `res_vec` and `res_err` load only at an edge where `req_valid` is high, and otherwise hold their values.
- R3: With `req_op`=0 (register swizzle), `req_pat` selects one pattern that is applied identically in every lane. The patterns, written with destination element d first, are:
  - 0 dcba (identity)
  - 1 cdab
  - 2 badc
  - 3 dacb
  - 4 aaaa
  - 5 bbbb
  - 6 cccc
  - 7 dddd
- R4: The cdab swizzle applied to elements 0..15 gives, from element 0 upward, 1,0,3,2,5,4,7,6,9,8,11,10,13,12,15,14. `req_mem` has no effect on a swizzle.
- R5: With `req_op`=1 (broadcast), `req_mem`=1 and `req_pat[1:0]`=1, element 0 of the source is replicated into all sixteen positions.
- R6: With `req_op`=1, `req_mem`=1 and `req_pat[1:0]`=2, elements 0..3 of the source are repeated into all four lanes.
- R7: With `req_op`=1, `req_mem`=1 and `req_pat[1:0]` equal to 0 or 3, the sixteen elements pass unchanged. The lowest-address element stays in bits [31:0].
- R8: With `req_op`=2 (in-lane shuffle), destination element k of every lane takes the source element of the same lane whose index is `req_imm[2k+1:2k]`. Arbitrary patterns such as dddc (imm 0xFE) are allowed.
- R9: With `req_op`=3 (cross-lane shuffle), destination lane k takes the whole source lane whose index is `req_imm[2k+1:2k]`. For example, imm 0x06 (aabc) gives lanes 2,1,0,0 from lane 0 upward.
- R10: A broadcast (`req_op`=1) requested with `req_mem`=0 passes the source through unchanged and sets `res_err`. Every other request leaves `res_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 swizzle, 1 broadcast, 2 in-lane shuffle, 3 cross-lane shuffle |
| req_mem | input | 1 | Operand comes from memory (needed for broadcast) |
| req_pat | input | 3 | Swizzle code, or broadcast kind in bits [1:0] |
| req_imm | input | 8 | Shuffle select word, 2 bits per destination position |
| req_vec | input | 512 | Source vector, element 0 in bits [31:0] |
| res_valid | output | 1 | Registered result valid |
| res_err | output | 1 | Broadcast was requested on a register operand |
| res_vec | output | 512 | Registered shaped operand |

## Verification
A wrong select word in either permute layer shows up as a misplaced element in `res_vec` on the very next cycle. To make that visible, the bench gives every source element a distinct value tagged with its own index, so a single compare exposes which source slot reached which destination. A faulty decode of the broadcast legality check appears as a wrong `res_err` one cycle after the request, together with a permuted instead of an untouched vector. A hold fault shows as `res_vec` changing in a cycle that follows an idle request.

// File: rtl/vsw_pkg.sv
package vsw_pkg;

    localparam int LANES      = 4;
    localparam int LANE_ELEMS = 4;
    localparam int NUM_ELEMS  = LANES * LANE_ELEMS;
    localparam int SEL_W      = $clog2(LANE_ELEMS);
    localparam int IMM_W      = SEL_W * LANE_ELEMS;

    typedef enum logic [1:0] {
        OP_SWZ     = 2'd0,
        OP_BCAST   = 2'd1,
        OP_SHUF_IN = 2'd2,
        OP_SHUF_X  = 2'd3
    } vsw_op_e;

    typedef enum logic [1:0] {
        BC_FULL = 2'd0,
        BC_ONE  = 2'd1,
        BC_FOUR = 2'd2,
        BC_RSVD = 2'd3
    } vsw_bcast_e;

    // Select word that leaves every position in place, and one that
    // routes position 0 everywhere.
    localparam logic [IMM_W-1:0] SEL_IDENT = 8'hE4;
    localparam logic [IMM_W-1:0] SEL_ZERO  = 8'h00;

    // Fixed swizzle code to in-lane select word (2 bits per destination,
    // destination a in the low field).
    function automatic logic [IMM_W-1:0] swz_sel(input logic [2:0] code);
        logic [IMM_W-1:0] s;
        case (code)
            3'd0:    s = 8'hE4;  // dcba
            3'd1:    s = 8'hB1;  // cdab
            3'd2:    s = 8'h4E;  // badc
            3'd3:    s = 8'hC9;  // dacb
            3'd4:    s = 8'h00;  // aaaa
            3'd5:    s = 8'h55;  // bbbb
            3'd6:    s = 8'hAA;  // cccc
            default: s = 8'hFF;  // dddd
        endcase
        return s;
    endfunction

endpackage

// File: rtl/vsw_lane_perm.sv
module vsw_lane_perm
    import vsw_pkg::*;
#(
    parameter int ELEM_W = 32
) (
    input  logic [LANE_ELEMS*ELEM_W-1:0] lane_in,
    input  logic [IMM_W-1:0]             sel,
    output logic [LANE_ELEMS*ELEM_W-1:0] lane_out
);

    for (genvar k = 0; k < LANE_ELEMS; k++) begin : g_dst
        logic [SEL_W-1:0] idx;
        assign idx = sel[k*SEL_W +: SEL_W];
        assign lane_out[k*ELEM_W +: ELEM_W] = lane_in[idx*ELEM_W +: ELEM_W];
    end

endmodule

// File: rtl/vsw_lane_xbar.sv
module vsw_lane_xbar
    import vsw_pkg::*;
#(
    parameter int ELEM_W = 32
) (
    input  logic [NUM_ELEMS*ELEM_W-1:0] vec_in,
    input  logic [IMM_W-1:0]            sel,
    output logic [NUM_ELEMS*ELEM_W-1:0] vec_out
);

    localparam int LANE_W = LANE_ELEMS * ELEM_W;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [SEL_W-1:0] idx;
        assign idx = sel[k*SEL_W +: SEL_W];
        assign vec_out[k*LANE_W +: LANE_W] = vec_in[idx*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/vsw_ctrl.sv
module vsw_ctrl
    import vsw_pkg::*;
(
    input  logic [1:0]       op,
    input  logic             mem_src,
    input  logic [2:0]       pat,
    input  logic [IMM_W-1:0] imm,
    output logic [IMM_W-1:0] intra_sel,
    output logic [IMM_W-1:0] inter_sel,
    output logic             illegal
);

    always_comb begin
        intra_sel = SEL_IDENT;
        inter_sel = SEL_IDENT;
        illegal   = 1'b0;
        case (vsw_op_e'(op))
            OP_SWZ:     intra_sel = swz_sel(pat);
            OP_SHUF_IN: intra_sel = imm;
            OP_SHUF_X:  inter_sel = imm;
            default: begin
                if (!mem_src) begin
                    illegal = 1'b1;
                end else begin
                    case (vsw_bcast_e'(pat[1:0]))
                        BC_ONE: begin
                            intra_sel = SEL_ZERO;
                            inter_sel = SEL_ZERO;
                        end
                        BC_FOUR: inter_sel = SEL_ZERO;
                        default: ;
                    endcase
                end
            end
        endcase
    end

endmodule

// File: rtl/vec_operand_shaper.sv
module vec_operand_shaper
    import vsw_pkg::*;
#(
    parameter int ELEM_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [1:0]                  req_op,
    input  logic                        req_mem,
    input  logic [2:0]                  req_pat,
    input  logic [IMM_W-1:0]            req_imm,
    input  logic [NUM_ELEMS*ELEM_W-1:0] req_vec,
    output logic                        res_valid,
    output logic                        res_err,
    output logic [NUM_ELEMS*ELEM_W-1:0] res_vec
);

    localparam int VEC_W  = NUM_ELEMS * ELEM_W;
    localparam int LANE_W = LANE_ELEMS * ELEM_W;

    typedef struct packed {
        logic             valid;
        logic             err;
        logic [VEC_W-1:0] data;
    } state_t;

    state_t state_d, state_q;

    logic [IMM_W-1:0] intra_sel, inter_sel;
    logic             illegal;
    logic [VEC_W-1:0] intra_vec, shaped_vec;

    vsw_ctrl u_ctrl (
        .op        (req_op),
        .mem_src   (req_mem),
        .pat       (req_pat),
        .imm       (req_imm),
        .intra_sel (intra_sel),
        .inter_sel (inter_sel),
        .illegal   (illegal)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        vsw_lane_perm #(.ELEM_W(ELEM_W)) u_perm (
            .lane_in  (req_vec[l*LANE_W +: LANE_W]),
            .sel      (intra_sel),
            .lane_out (intra_vec[l*LANE_W +: LANE_W])
        );
    end

    vsw_lane_xbar #(.ELEM_W(ELEM_W)) u_xbar (
        .vec_in  (intra_vec),
        .sel     (inter_sel),
        .vec_out (shaped_vec)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = req_valid;
        if (req_valid) begin
            state_d.err  = illegal;
            state_d.data = shaped_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign res_valid = state_q.valid;
    assign res_err   = state_q.err;
    assign res_vec   = state_q.data;

endmodule

// File: rtl/vsw_checker.sv
module vsw_checker
    import vsw_pkg::*;
#(
    parameter int ELEM_W = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic [1:0]                  req_op,
    input logic                        req_mem,
    input logic [2:0]                  req_pat,
    input logic [NUM_ELEMS*ELEM_W-1:0] req_vec,
    input logic                        res_valid,
    input logic                        res_err,
    input logic [NUM_ELEMS*ELEM_W-1:0] res_vec
);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid && $stable(res_vec) && $stable(res_err)));

    // R10
    err_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op != 2'd1) |=> !res_err);

    // R10
    err_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd1 && !req_mem) |=> (res_err && res_vec == $past(req_vec)));

    // R5
    one_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd1 && req_mem && req_pat[1:0] == 2'd1)
        |=> (res_vec == {NUM_ELEMS{$past(req_vec[ELEM_W-1:0])}}));

    // R3
    ident_swz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd0 && req_pat == 3'd0) |=> (res_vec == $past(req_vec)));

endmodule

bind vec_operand_shaper vsw_checker #(.ELEM_W(ELEM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_mem   (req_mem),
    .req_pat   (req_pat),
    .req_vec   (req_vec),
    .res_valid (res_valid),
    .res_err   (res_err),
    .res_vec   (res_vec)
);

// File: tb/vec_operand_shaper_tb.sv
module vec_operand_shaper_tb;

    localparam int CLK_PERIOD = 10;
    localparam int EW = 32;
    localparam int NE = 16;

    typedef struct packed {
        logic [1:0]  op;
        logic        mem;
        logic [2:0]  pat;
        logic [7:0]  imm;
        logic [63:0] idx;   // nibble j = source element for destination j
        logic        err;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 1'b0, 3'd0, 8'h00, 64'hFEDC_BA98_7654_3210, 1'b0}, // R3 dcba
        '{2'd0, 1'b0, 3'd1, 8'h00, 64'hEFCD_AB89_6745_2301, 1'b0}, // R4 cdab
        '{2'd0, 1'b0, 3'd2, 8'h00, 64'hDCFE_98BA_5476_1032, 1'b0}, // R3 badc
        '{2'd0, 1'b0, 3'd3, 8'h00, 64'hFCED_B8A9_7465_3021, 1'b0}, // R3 dacb
        '{2'd0, 1'b0, 3'd4, 8'h00, 64'hCCCC_8888_4444_0000, 1'b0}, // R3 aaaa
        '{2'd0, 1'b0, 3'd5, 8'h00, 64'hDDDD_9999_5555_1111, 1'b0}, // R3 bbbb
        '{2'd0, 1'b0, 3'd6, 8'h00, 64'hEEEE_AAAA_6666_2222, 1'b0}, // R3 cccc
        '{2'd0, 1'b0, 3'd7, 8'h00, 64'hFFFF_BBBB_7777_3333, 1'b0}, // R3 dddd
        '{2'd0, 1'b1, 3'd1, 8'h00, 64'hEFCD_AB89_6745_2301, 1'b0}, // R4 mem flag ignored
        '{2'd1, 1'b1, 3'd1, 8'h00, 64'h0000_0000_0000_0000, 1'b0}, // R5
        '{2'd1, 1'b1, 3'd2, 8'h00, 64'h3210_3210_3210_3210, 1'b0}, // R6
        '{2'd1, 1'b1, 3'd0, 8'h00, 64'hFEDC_BA98_7654_3210, 1'b0}, // R7
        '{2'd1, 1'b1, 3'd3, 8'h00, 64'hFEDC_BA98_7654_3210, 1'b0}, // R7 code 3
        '{2'd1, 1'b0, 3'd1, 8'h00, 64'hFEDC_BA98_7654_3210, 1'b1}, // R10
        '{2'd2, 1'b0, 3'd0, 8'hFE, 64'hFFFE_BBBA_7776_3332, 1'b0}, // R8 dddc
        '{2'd2, 1'b0, 3'd0, 8'h1B, 64'hCDEF_89AB_4567_0123, 1'b0}, // R8 reverse
        '{2'd3, 1'b0, 3'd0, 8'h06, 64'h3210_3210_7654_BA98, 1'b0}, // R9 aabc
        '{2'd3, 1'b0, 3'd0, 8'h1B, 64'h3210_7654_BA98_FEDC, 1'b0}, // R9 reverse
        '{2'd1, 1'b0, 3'd2, 8'h00, 64'hFEDC_BA98_7654_3210, 1'b1}, // R10
        '{2'd2, 1'b1, 3'd0, 8'hE4, 64'hFEDC_BA98_7654_3210, 1'b0}, // R10 err clears
        '{2'd3, 1'b1, 3'd5, 8'hE4, 64'hFEDC_BA98_7654_3210, 1'b0}  // R9 identity
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_op = '0;
    logic              req_mem = 1'b0;
    logic [2:0]        req_pat = '0;
    logic [7:0]        req_imm = '0;
    logic [NE*EW-1:0]  req_vec = '0;
    logic              res_valid, res_err;
    logic [NE*EW-1:0]  res_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_operand_shaper u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_mem   (req_mem),
        .req_pat   (req_pat),
        .req_imm   (req_imm),
        .req_vec   (req_vec),
        .res_valid (res_valid),
        .res_err   (res_err),
        .res_vec   (res_vec)
    );

    function automatic logic [NE*EW-1:0] mk_src(input int k);
        logic [NE*EW-1:0] v;
        for (int i = 0; i < NE; i++) v[i*EW +: EW] = 32'h5A00_0000 | (k << 8) | i;
        return v;
    endfunction

    function automatic logic [NE*EW-1:0] gather(input logic [NE*EW-1:0] s, input logic [63:0] idx);
        logic [NE*EW-1:0] v;
        for (int j = 0; j < NE; j++) v[j*EW +: EW] = s[int'(idx[j*4 +: 4])*EW +: EW];
        return v;
    endfunction

    task automatic check(input string req, input logic [NE*EW-1:0] act, input logic [NE*EW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input vec_t t, input logic [NE*EW-1:0] s);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = t.op;
        req_mem   = t.mem;
        req_pat   = t.pat;
        req_imm   = t.imm;
        req_vec   = s;
    endtask

    initial begin
        logic [NE*EW-1:0] held;
        logic [NE*EW-1:0] s;
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 valid in reset", {511'd0, res_valid}, '0);
        check("R1 err in reset", {511'd0, res_err}, '0);
        check("R1 data in reset", res_vec, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", {511'd0, res_valid}, '0);
        check("R1 data after reset", res_vec, '0);

        for (int n = 0; n < NV; n++) begin
            s = mk_src(n);
            send(TBL[n], s);
            @(negedge clk);
            req_valid = 1'b0;
            check($sformatf("R2 valid row %0d", n), {511'd0, res_valid}, {511'd0, 1'b1});
            check($sformatf("R3-table data row %0d", n), res_vec, gather(s, TBL[n].idx));
            check($sformatf("R10 err row %0d", n), {511'd0, res_err}, {511'd0, TBL[n].err});
        end

        // R2: idle cycle with new inputs keeps result
        send(TBL[1], mk_src(40));
        @(negedge clk);
        held = res_vec;
        req_valid = 1'b0;
        req_op = 2'd1; req_mem = 1'b0; req_vec = mk_src(41);
        @(negedge clk);
        check("R2 idle valid low", {511'd0, res_valid}, '0);
        check("R2 idle data held", res_vec, held);
        check("R2 idle err held", {511'd0, res_err}, '0);

        // R2: back-to-back requests, each result one cycle later
        send(TBL[9], mk_src(50));
        send(TBL[16], mk_src(51));
        check("R5 back-to-back first", res_vec, gather(mk_src(50), TBL[9].idx));
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 back-to-back second", res_vec, gather(mk_src(51), TBL[16].idx));
        check("R2 back-to-back valid", {511'd0, res_valid}, {511'd0, 1'b1});

        // R10 then legal: error drops
        send(TBL[13], mk_src(60));
        send(TBL[10], mk_src(61));
        check("R10 err set", {511'd0, res_err}, {511'd0, 1'b1});
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 err cleared", {511'd0, res_err}, '0);
        check("R6 after err", res_vec, gather(mk_src(61), TBL[10].idx));

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule